// File: doc/BRIEF.md
# Multi-rate output serializer

This block turns a stream of variable-length event words into bits on two output lanes. An upstream event builder offers one word at a time, together with its length in bits. Each accepted word is appended behind the bits still waiting in a 32-bit staging register. The staging register moves its contents toward bit 0 every clock by a step of 1, 2 or 4 positions. The step follows the rate mode.

Each clock, a 4-bit output register is refreshed from the lowest staging bits. It describes two lanes across the two halves of a clock period: `dout[0]` is lane A in the first half, `dout[1]` is lane B in the first half, `dout[2]` is lane A in the second half and `dout[3]` is lane B in the second half. A clock-edge driver outside the block turns this register into the pin waveforms.

With no data to send, the lanes carry zeros, so a receiver can search for the `11101` start pattern that leads every event. A test mode replaces the data on the lanes with an alternating 0/1 pattern at the selected rate.

Top module: `mrate_serializer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `dout` is 0000 and `word_ready` is 1.
- R2: Word bits are sent least significant first. Bit `i` of an accepted word comes out after every bit of earlier words and before bit `i+1`. Lengths from 9 to 26 are supported.
- R3: In mode 00 (one lane, one bit per clock), the staging register advances one position per clock and all four `dout` bits equal the next staged bit.
- R4: In mode 10 (one lane, two bits per clock), the register advances two positions. `dout[1:0]` both carry the first staged bit and `dout[3:2]` both carry the second, so the two lanes are identical.
- R5: In mode 01 (two lanes, one bit per lane per clock), the register advances two positions. Lane A (`dout[0]`, `dout[2]`) carries the first staged bit and lane B (`dout[1]`, `dout[3]`) carries the second.
- R6: In mode 11 (two lanes, two bits per lane per clock), the register advances four positions and `dout[k]` carries staged bit `k`.
- R7: `word_ready` is 1 exactly when the pattern test is off and at most 5 staged bits remain after this clock's advance. When a word is accepted, its bits follow the remaining ones with no gap.
- R8: When the staged bits run out, the missing positions are sent as 0. An idle serializer drives `dout` = 0000.
- R9: While `pattern_en` is 1 in mode 00 or 01, `dout` is 0000 on the first cycle and then alternates between 1111 and 0000 every clock.
- R10: While `pattern_en` is 1 in mode 10 or 11, `dout` is 1100. Throughout pattern mode, `word_ready` is 0 and staged data keeps advancing unseen.
- R11: Bits of `word_data` at positions at or above `word_len` never reach the lanes.
- R12: If a word is accepted at clock edge k, its first bits appear on `dout` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Rate mode: 00 1x1, 01 2x1, 10 1x2, 11 2x2 (lanes x bits per lane per clock) |
| pattern_en | input | 1 | Alternating-pattern test mode |
| word_valid | input | 1 | Upstream offers a word |
| word_data | input | 26 | Word bits, bit 0 sent first |
| word_len | input | 5 | Number of valid bits in `word_data` (9 to 26) |
| word_ready | output | 1 | Word is taken on this clock when valid |
| dout | output | 4 | Lane bits: [0] A early, [1] B early, [2] A late, [3] B late |

## Verification
Words of random length, with random bits above the length, are pushed back to back in every rate mode. This separates the lane mapping of each mode and shows whether stale high bits leak onto the lanes. Sparse words, offered with gaps, force the staging register to run dry mid-word in the four-bit mode, which exposes how zeros are filled in and how the ready threshold behaves. Pattern windows entered with a word pending confirm that no word is taken and that staged data drains unseen. A directed single word checks the one-cycle output latency against the first nibble.

// File: rtl/ser_pkg.sv
package ser_pkg;

  typedef enum logic [1:0] {
    RATE_1L_1B = 2'b00,
    RATE_2L_1B = 2'b01,
    RATE_1L_2B = 2'b10,
    RATE_2L_2B = 2'b11
  } rate_mode_e;

  // Staged bits consumed per clock for a rate mode.
  function automatic logic [2:0] step_of(input logic [1:0] m);
    case (m)
      RATE_1L_1B: step_of = 3'd1;
      RATE_2L_2B: step_of = 3'd4;
      default:    step_of = 3'd2;
    endcase
  endfunction

  // Spread the lowest staged bits over {B late, A late, B early, A early}.
  function automatic logic [3:0] lane_map(input logic [1:0] m, input logic [3:0] s);
    case (m)
      RATE_1L_1B: lane_map = {4{s[0]}};
      RATE_1L_2B: lane_map = {s[1], s[1], s[0], s[0]};
      RATE_2L_1B: lane_map = {s[1], s[0], s[1], s[0]};
      default:    lane_map = s;
    endcase
  endfunction

endpackage

// File: rtl/ser_shifter.sv
module ser_shifter
  import ser_pkg::*;
#(
  parameter int SHREG_W = 32,
  parameter int WORD_W  = 26,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic               hold,
  input  logic               word_valid,
  input  logic [WORD_W-1:0]  word_data,
  input  logic [CNT_W-1:0]   word_len,
  output logic               word_ready,
  output logic               accept,
  output logic               count_zero,
  output logic [3:0]         low_bits
);

  localparam int CNT_MAX = (2 ** CNT_W) - 1;
  localparam int THRESH  = CNT_MAX - WORD_W;

  logic [SHREG_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cnt_after;
  logic [CNT_W-1:0]   step_w;
  logic [SHREG_W-1:0] word_mask;
  logic [SHREG_W-1:0] word_ext;

  always_comb begin
    step_w     = CNT_W'(step_of(mode));
    cnt_after  = (cnt > step_w) ? (cnt - step_w) : '0;
    word_ready = !hold && (cnt_after <= CNT_W'(THRESH));
    accept     = word_valid && word_ready;
    word_mask  = ~({SHREG_W{1'b1}} << word_len);
    word_ext   = SHREG_W'(word_data) & word_mask;
    count_zero = (cnt == '0);
    low_bits   = shreg[3:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else begin
      shreg <= (shreg >> step_of(mode)) | (accept ? (word_ext << cnt_after) : '0);
      cnt   <= cnt_after + (accept ? word_len : '0);
    end
  end

  // R7: an empty staging register always takes a word unless in pattern mode
  p_ready_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_zero && !hold) |-> word_ready);

  // R10: pattern mode never takes a word
  p_hold_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !accept);

  // R8: without a new word the remaining count never grows
  p_drain_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (cnt <= $past(cnt)));

  // R2: accepted lengths stay within the supported range
  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (word_len >= CNT_W'(9) && word_len <= CNT_W'(WORD_W)));

endmodule

// File: rtl/ser_outmap.sv
module ser_outmap
  import ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       pattern_en,
  input  logic [3:0] low_bits,
  output logic [3:0] dout
);

  logic phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= '0;
      phase <= 1'b0;
    end else if (pattern_en) begin
      dout  <= mode[1] ? 4'b1100 : {4{phase}};
      phase <= ~phase;
    end else begin
      dout  <= lane_map(mode, low_bits);
      phase <= 1'b0;
    end
  end

  // R3, R4: single-lane modes put identical bits on both lanes
  p_single_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RATE_1L_1B || mode == RATE_1L_2B) |=> (dout[0] == dout[1] && dout[2] == dout[3]));

  // R10: fast pattern is low then high within each clock
  p_pattern_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pattern_en && mode[1]) |=> (dout == 4'b1100));

  // R9: slow pattern keeps all four bits equal
  p_pattern_slow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pattern_en && !mode[1]) |=> (dout == 4'b0000 || dout == 4'b1111));

endmodule

// File: rtl/mrate_serializer.sv
module mrate_serializer
  import ser_pkg::*;
#(
  parameter int SHREG_W = 32,
  parameter int WORD_W  = 26,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              pattern_en,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic [CNT_W-1:0]  word_len,
  output logic              word_ready,
  output logic [3:0]        dout
);

  logic       accept;
  logic       count_zero;
  logic [3:0] low_bits;

  ser_shifter #(.SHREG_W(SHREG_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) i_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .hold       (pattern_en),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_len   (word_len),
    .word_ready (word_ready),
    .accept     (accept),
    .count_zero (count_zero),
    .low_bits   (low_bits)
  );

  ser_outmap i_outmap (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .pattern_en (pattern_en),
    .low_bits   (low_bits),
    .dout       (dout)
  );

  // R8: an empty serializer with nothing arriving drives zeros next clock
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count_zero && !accept && !pattern_en) |=> (dout == 4'b0000));

  // R1: ready is high in the first cycle after reset
  p_ready_after_reset_r1: assert property (@(posedge clk)
    (!rst_n && !pattern_en) |=> word_ready);

endmodule

// File: tb/test_mrate_serializer.sv
module test_mrate_serializer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        pattern_en = 1'b0;
  logic        word_valid = 1'b0;
  logic [25:0] word_data = '0;
  logic [4:0]  word_len = 5'd9;
  logic        word_ready;
  logic [3:0]  dout;

  int n_checks = 0;
  int n_fails  = 0;

  bit   q[$];
  logic [3:0] exp_dout = '0;
  bit   ph = 0;

  always #5 clk = ~clk;

  mrate_serializer i_mrate_serializer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pattern_en(pattern_en),
    .word_valid(word_valid), .word_data(word_data), .word_len(word_len),
    .word_ready(word_ready), .dout(dout)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bits_per_clk(input logic [1:0] m);
    if (m == 2'b00) return 1;
    if (m == 2'b11) return 4;
    return 2;
  endfunction

  function automatic bit model_ready();
    int left = q.size() - bits_per_clk(mode);
    if (left < 0) left = 0;
    return !pattern_en && (left <= 5);
  endfunction

  function automatic bit qbit(input int i);
    return (i < q.size()) ? q[i] : 1'b0;
  endfunction

  // Reference model: bit queue updated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_dout <= '0;
      ph = 0;
    end else begin
      bit rdy;
      logic [3:0] e;
      rdy = model_ready();
      if (pattern_en) begin
        e = mode[1] ? 4'b1100 : {4{ph}};
        ph = !ph;
      end else begin
        ph = 0;
        case (mode)
          2'b00: e = {qbit(0), qbit(0), qbit(0), qbit(0)};
          2'b10: begin e[0] = qbit(0); e[1] = qbit(0); e[2] = qbit(1); e[3] = qbit(1); end
          2'b01: begin e[0] = qbit(0); e[2] = qbit(0); e[1] = qbit(1); e[3] = qbit(1); end
          default: e = {qbit(3), qbit(2), qbit(1), qbit(0)};
        endcase
      end
      exp_dout <= e;
      for (int k = 0; k < bits_per_clk(mode); k++)
        if (q.size() > 0) void'(q.pop_front());
      if (word_valid && rdy)
        for (int k = 0; k < int'(word_len); k++) q.push_back(word_data[k]);
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      if (pattern_en) tag = mode[1] ? "R10 fast pattern" : "R9 slow pattern";
      else case (mode)
        2'b00: tag = "R2 R3 R8 R11 mode00 lanes";
        2'b10: tag = "R2 R4 R8 R11 mode10 lanes";
        2'b01: tag = "R2 R5 R8 R11 mode01 lanes";
        default: tag = "R2 R6 R8 R11 mode11 lanes";
      endcase
      check(dout == exp_dout, tag, dout, exp_dout);
      check(word_ready == model_ready(), "R7 ready threshold", word_ready, model_ready());
    end
  end

  task automatic send(input logic [4:0] len, input logic [25:0] data);
    bit r;
    word_valid = 1'b1;
    word_len   = len;
    word_data  = data;
    do begin
      @(negedge clk);
      r = word_ready;
      @(posedge clk);
    end while (!r);
    #3;
    word_valid = 1'b0;
    word_data  = {26{1'b1}};
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=0 cycles left", 1);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(dout == 4'b0000, "R1 reset dout", dout, 0);
    check(word_ready == 1'b1, "R1 reset ready", word_ready, 1);
    @(posedge clk); #3;
    rst_n = 1'b1;
    @(negedge clk);
    check(dout == 4'b0000, "R1 first cycle dout", dout, 0);
    check(word_ready == 1'b1, "R1 first cycle ready", word_ready, 1);

    // R12: latency of the first nibble in mode 11
    mode = 2'b11;
    #0;
    @(posedge clk); #3;
    send(5'd9, 26'h3FFE1ED);
    @(negedge clk);
    check(dout == 4'b0000, "R12 one cycle before data", dout, 0);
    @(negedge clk);
    check(dout == 4'hD, "R12 first nibble", dout, 4'hD);
    idle(6);

    // R11: high garbage in mode 00
    mode = 2'b00;
    idle(1);
    send(5'd9, 26'h3FFFEAA);
    repeat (12) @(negedge clk);
    check(dout == 4'b0000, "R11 bits above length stay off lanes", dout, 0);
    idle(1);

    // R7: a full word into an empty register closes ready
    send(5'd26, 26'h2A5A5A5);
    @(negedge clk);
    check(word_ready == 1'b0, "R7 ready low after long word", word_ready, 0);
    idle(30);

    // Back-to-back random words in every mode
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int w = 0; w < 12; w++)
        send(5'(9 + ($urandom % 18)), 26'($urandom));
      idle(40);
    end

    // Sparse words in mode 11: underrun mid-stream (R8)
    mode = 2'b11;
    for (int w = 0; w < 10; w++) begin
      send(5'(9 + ($urandom % 18)), 26'($urandom));
      idle(1 + ($urandom % 6));
    end
    idle(20);

    // Pattern windows with a pending word (R9, R10)
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      send(5'd20, 26'($urandom));
      pattern_en = 1'b1;
      word_valid = 1'b1;
      word_len   = 5'd12;
      word_data  = 26'h0000ABC;
      repeat (3) begin
        @(negedge clk);
        check(word_ready == 1'b0, "R10 no word taken in pattern", word_ready, 0);
      end
      idle(4);
      word_valid = 1'b0;
      pattern_en = 1'b0;
      idle(15);
    end

    // Mode change during a stream
    mode = 2'b01;
    send(5'd26, 26'($urandom));
    send(5'd17, 26'($urandom));
    mode = 2'b10;
    send(5'd13, 26'($urandom));
    idle(40);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule